// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte Lanes

This block is a single-port synchronous memory with a processor-style burst interface. On every rising clock edge it samples an address, two active-low address strobes (one for a processor, one for a cache controller), three chip selects of mixed polarity, a step input, and a set of write controls. When a strobe is accepted it latches a start address. After that, each cycle with the step input low moves to the next word of a four-word linear burst, and each cycle with step high reaches the same word again.

Writes are decided per byte lane in each access cycle. A global write forces every lane to be written. Otherwise a lane-write enable and a per-lane select together pick which lanes are written. Any access cycle that writes no lane is a read. Read data comes out of a registered read port one cycle after the access. A drive flag, gated by an asynchronous output enable, marks when that data is valid. The drive flag is held off for the first read after the device was deselected.

Top module: `sburst_sram`

## Requirements
- R1: A strobe cycle starts an access at `addr_i` only if `sel_a_n` is low, `sel_b` is high and `sel_c_n` is low. A read started that way shows the stored word on `rdata` with `rdata_en` high in the following cycle, provided `out_en_n` is low.
- R2: While `sel_a_n` is high, the processor strobe `stb_cpu_n` is ignored. In that cycle the device behaves as if no strobe was present, so an active burst goes on stepping.
- R3: When both strobes are low and `sel_a_n` is low, the processor strobe takes the cycle. That cycle is always a read of `addr_i`, and the write inputs have no effect.
- R4: On a start, the two low address bits are loaded into a burst counter. Each later cycle with `step_n` low and no accepted strobe increments the counter. The counter wraps from 3 to 0, and the upper address bits stay as captured.
- R5: A selected cycle with no accepted strobe and `step_n` high accesses the same word again.
- R6: With `wall_n` low, a write cycle writes both lanes, whatever `lane_wen_n` and `lane_sel_n` are. That cycle produces no read data.
- R7: With `wall_n` high and `lane_wen_n` low, lane i is written exactly when `lane_sel_n[i]` is low. Lane 0 is `wdata[7:0]`. With `lane_wen_n` high, the lane selects have no effect and the cycle is a read.
- R8: `out_en_n` acts on `rdata_en` combinationally, without waiting for a clock edge.
- R9: After a read that starts from the deselected state, `rdata_en` stays low in the following cycle, even with `out_en_n` low.
- R10: An accepted strobe while the chip selects are inactive deselects the device. While the device is deselected, `step_n` has no effect and no read data is produced.
- R11: After reset the device is deselected and `rdata_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Word address |
| stb_cpu_n | input | 1 | Processor address strobe, active low |
| stb_ctl_n | input | 1 | Controller address strobe, active low |
| sel_a_n | input | 1 | Chip select A, active low |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| step_n | input | 1 | Burst step, active low |
| wall_n | input | 1 | Write all lanes, active low |
| lane_wen_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data |
| rdata_en | output | 1 | Read data drive flag |

## Verification
The properties assume that the strobes, selects and step input are known values at every clock edge after reset. They also assume that `out_en_n` changes only between edges. The stimulus sets every input at the falling edge and never leaves one undriven. The first read of any address comes after a write to it, so unwritten storage is never compared. The output-enable check toggles `out_en_n` within a single clock phase and restores it before the next sample.

// File: rtl/sburst_sram_pkg.sv
package sburst_sram_pkg;
  // What a sampled cycle does to the address path.
  typedef enum logic [2:0] {
    CY_IDLE,   // deselected, no strobe
    CY_LOAD,   // strobe accepted with chip selected
    CY_DESEL,  // strobe accepted with chip not selected
    CY_STEP,   // burst advances
    CY_HOLD    // burst stays on current word
  } cyc_kind_e;

  localparam int BURST_W = 2;
endpackage

// File: rtl/sburst_addr_ctl.sv
module sburst_addr_ctl
  import sburst_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              stb_cpu_n,
  input  logic              stb_ctl_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              step_n,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_valid,
  output logic              wr_allowed,
  output logic              first_acc,
  output logic              dev_sel,
  output logic [BURST_W-1:0] burst_cnt
);
  localparam int UP_W = ADDR_W - BURST_W;

  logic [UP_W-1:0]    upper_q;
  logic [BURST_W-1:0] cnt_nx;
  logic               cpu_ok, any_stb, chip_on;
  cyc_kind_e          kind;

  assign cpu_ok  = !stb_cpu_n && !sel_a_n;
  assign any_stb = cpu_ok || !stb_ctl_n;
  assign chip_on = !sel_a_n && sel_b && !sel_c_n;

  always_comb begin
    if (any_stb)            kind = chip_on ? CY_LOAD : CY_DESEL;
    else if (!dev_sel)      kind = CY_IDLE;
    else if (!step_n)       kind = CY_STEP;
    else                    kind = CY_HOLD;
  end

  always_comb begin
    unique case (kind)
      CY_LOAD: cnt_nx = addr_i[BURST_W-1:0];
      CY_STEP: cnt_nx = burst_cnt + 1'b1;
      default: cnt_nx = burst_cnt;
    endcase
  end

  assign acc_addr   = {(kind == CY_LOAD) ? addr_i[ADDR_W-1:BURST_W] : upper_q, cnt_nx};
  assign acc_valid  = (kind == CY_LOAD) || (kind == CY_STEP) || (kind == CY_HOLD);
  // A processor-started cycle is never a write.
  assign wr_allowed = acc_valid && !((kind == CY_LOAD) && cpu_ok);
  assign first_acc  = (kind == CY_LOAD) && !dev_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q   <= '0;
      burst_cnt <= '0;
      dev_sel   <= 1'b0;
    end else begin
      burst_cnt <= cnt_nx;
      if (kind == CY_LOAD) begin
        upper_q <= addr_i[ADDR_W-1:BURST_W];
        dev_sel <= 1'b1;
      end else if (kind == CY_DESEL) begin
        dev_sel <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sburst_wr_dec.sv
module sburst_wr_dec #(
  parameter int LANES = 2
) (
  input  logic             allow,
  input  logic             wall_n,
  input  logic             lane_wen_n,
  input  logic [LANES-1:0] lane_sel_n,
  output logic [LANES-1:0] lane_we
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_we[l] = allow && (!wall_n || (!lane_wen_n && !lane_sel_n[l]));
  end
endmodule

// File: rtl/sburst_mem.sv
module sburst_mem #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] ram [DEPTH];
    logic [LANE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (we[l]) ram[addr] <= wdata[l*LANE_W +: LANE_W];
      q <= ram[addr];
    end
    assign rdata[l*LANE_W +: LANE_W] = q;
  end
endmodule

// File: rtl/sburst_sram.sv
module sburst_sram #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    stb_cpu_n,
  input  logic                    stb_ctl_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    step_n,
  input  logic                    wall_n,
  input  logic                    lane_wen_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    out_en_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_en
);
  localparam int DW = LANES * LANE_W;

  logic [ADDR_W-1:0] acc_addr;
  logic              acc_valid, wr_allowed, first_acc, dev_sel;
  logic [1:0]        burst_cnt;
  logic [LANES-1:0]  lane_we;
  logic              rd_pend, mask_q;
  logic [DW-1:0]     mem_q;

  sburst_addr_ctl #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .addr_i(addr_i),
    .stb_cpu_n(stb_cpu_n), .stb_ctl_n(stb_ctl_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .step_n(step_n),
    .acc_addr(acc_addr), .acc_valid(acc_valid), .wr_allowed(wr_allowed),
    .first_acc(first_acc), .dev_sel(dev_sel), .burst_cnt(burst_cnt)
  );

  sburst_wr_dec #(.LANES(LANES)) u_wdec (
    .allow(wr_allowed), .wall_n(wall_n), .lane_wen_n(lane_wen_n),
    .lane_sel_n(lane_sel_n), .lane_we(lane_we)
  );

  sburst_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .we(lane_we), .addr(acc_addr), .wdata(wdata), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend <= 1'b0;
      mask_q  <= 1'b0;
    end else begin
      rd_pend <= acc_valid && (lane_we == '0);
      mask_q  <= first_acc;
    end
  end

  assign rdata    = mem_q;
  assign rdata_en = rd_pend && !mask_q && !out_en_n;
endmodule

// File: rtl/sburst_sram_chk.sv
module sburst_sram_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] addr_lo,
  input logic       stb_cpu_n,
  input logic       stb_ctl_n,
  input logic       sel_a_n,
  input logic       sel_b,
  input logic       sel_c_n,
  input logic       step_n,
  input logic       wall_n,
  input logic       rdata_en,
  input logic [1:0] cnt,
  input logic       dev_sel
);
  logic cpu_ok, go, on_all;
  assign cpu_ok = !stb_cpu_n && !sel_a_n;
  assign go     = cpu_ok || !stb_ctl_n;
  assign on_all = !sel_a_n && sel_b && !sel_c_n;

  assert_load_cnt_R4: assert property (@(posedge clk) disable iff (rst)
    (go && on_all) |=> (cnt == $past(addr_lo)));

  assert_step_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (!go && dev_sel && !step_n) |=> (cnt == $past(cnt) + 2'd1));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!go && (step_n || !dev_sel)) |=> $stable(cnt));

  assert_desel_R10: assert property (@(posedge clk) disable iff (rst)
    (go && !on_all) |=> (!dev_sel && !rdata_en));

  assert_first_mask_R9: assert property (@(posedge clk) disable iff (rst)
    (go && on_all && !dev_sel) |=> !rdata_en);

  assert_wall_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (!cpu_ok && !stb_ctl_n && on_all && !wall_n) |=> !rdata_en);
endmodule

bind sburst_sram sburst_sram_chk u_chk (
  .clk(clk), .rst(rst), .addr_lo(addr_i[1:0]),
  .stb_cpu_n(stb_cpu_n), .stb_ctl_n(stb_ctl_n),
  .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
  .step_n(step_n), .wall_n(wall_n), .rdata_en(rdata_en),
  .cnt(burst_cnt), .dev_sel(dev_sel)
);

// File: tb/sburst_sram_test.sv
`timescale 1ns/100ps
module sburst_sram_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  addr_i = '0;
  logic        stb_cpu_n = 1'b1, stb_ctl_n = 1'b1;
  logic        sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
  logic        step_n = 1'b1, wall_n = 1'b1, lane_wen_n = 1'b1;
  logic [1:0]  lane_sel_n = 2'b11;
  logic        out_en_n = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rdata_en;

  int checks = 0, errors = 0;
  bit done = 0;
  bit    qe[$];
  logic [15:0] qd[$];
  string qt[$];

  always #2.5 clk = ~clk;

  sburst_sram uut (
    .clk(clk), .rst(rst), .addr_i(addr_i),
    .stb_cpu_n(stb_cpu_n), .stb_ctl_n(stb_ctl_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .step_n(step_n), .wall_n(wall_n), .lane_wen_n(lane_wen_n),
    .lane_sel_n(lane_sel_n), .out_en_n(out_en_n),
    .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en)
  );

  task automatic note(input bit ok, input string tag,
                      input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle and push what the output must show after its edge.
  task automatic cyc(input bit sp, input bit sc, input bit sa, input bit sb,
                     input bit scn, input bit st, input bit wa, input bit lw,
                     input logic [1:0] ls, input logic [9:0] a,
                     input logic [15:0] wd, input bit xe,
                     input logic [15:0] xd, input string tag);
    @(negedge clk);
    stb_cpu_n = sp; stb_ctl_n = sc; sel_a_n = sa; sel_b = sb; sel_c_n = scn;
    step_n = st; wall_n = wa; lane_wen_n = lw; lane_sel_n = ls;
    addr_i = a; wdata = wd;
    qe.push_back(xe); qd.push_back(xd); qt.push_back(tag);
  endtask

  task automatic rd_start(input logic [9:0] a, input bit xe,
                          input logic [15:0] xd, input string tag);
    cyc(1, 0, 0, 1, 0, 1, 1, 1, 2'b11, a, 16'h0, xe, xd, tag);
  endtask
  task automatic wr_start(input logic [9:0] a, input bit wa, input bit lw,
                          input logic [1:0] ls, input logic [15:0] wd,
                          input string tag);
    cyc(1, 0, 0, 1, 0, 1, wa, lw, ls, a, wd, 0, 16'h0, tag);
  endtask
  task automatic step_rd(input bit st, input bit xe, input logic [15:0] xd,
                         input string tag);
    cyc(1, 1, 0, 1, 0, st, 1, 1, 2'b11, 10'h3ff, 16'h0, xe, xd, tag);
  endtask
  task automatic step_wr(input bit wa, input bit lw, input logic [1:0] ls,
                         input logic [15:0] wd, input string tag);
    cyc(1, 1, 0, 1, 0, 0, wa, lw, ls, 10'h3ff, wd, 0, 16'h0, tag);
  endtask

  // Monitor: pops one expectation per edge, samples 2 ns after it.
  initial forever begin
    @(posedge clk);
    #2;
    if (qe.size() > 0) begin
      bit xe; logic [15:0] xd; string tg;
      xe = qe.pop_front(); xd = qd.pop_front(); tg = qt.pop_front();
      note((rdata_en === xe) && (!xe || rdata === xd), tg,
           {rdata_en, rdata}, {xe, xd});
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    note(rdata_en === 1'b0, "R11 reset", {rdata_en, 16'h0}, 17'h0);

    // Fill 0x10..0x13 with global writes, lane selects inactive (R6).
    wr_start(10'h010, 0, 1, 2'b11, 16'hA010, "R6 wall start");
    step_wr(0, 1, 2'b11, 16'hA011, "R6 wall step");
    step_wr(0, 1, 2'b11, 16'hA012, "R6 wall step");
    step_wr(0, 1, 2'b11, 16'hA013, "R6 wall step");

    rd_start(10'h012, 1, 16'hA012, "R1 read start");
    step_rd(0, 1, 16'hA013, "R4 step");
    step_rd(0, 1, 16'hA010, "R4 wrap");
    step_rd(1, 1, 16'hA010, "R5 hold");

    // R8: output enable acts without a clock edge.
    @(posedge clk);
    #1 out_en_n = 1'b1;
    #0.5 note(rdata_en === 1'b0, "R8 oe high", {rdata_en, rdata}, 17'h0);
    out_en_n = 1'b0;
    #0.2 note(rdata_en === 1'b1 && rdata === 16'hA010, "R8 oe low",
              {rdata_en, rdata}, {1'b1, 16'hA010});

    // Lane writes (R7), lane 0 is wdata[7:0].
    step_wr(1, 0, 2'b10, 16'h55BB, "R7 lane0 write");
    step_wr(1, 0, 2'b01, 16'hCC77, "R7 lane1 write");
    cyc(1, 1, 0, 1, 0, 0, 1, 1, 2'b00, 10'h3ff, 16'hEEEE, 1, 16'hA013,
        "R7 selects without enable read");
    wr_start(10'h020, 0, 0, 2'b10, 16'h1234, "R6 wall overrides selects");
    rd_start(10'h011, 1, 16'hA0BB, "R7 lane0 readback");
    step_rd(0, 1, 16'hCC12, "R7 lane1 readback");
    rd_start(10'h020, 1, 16'h1234, "R6 override readback");

    // R3: both strobes, processor wins: read, no write.
    cyc(0, 0, 0, 1, 0, 1, 0, 0, 2'b00, 10'h010, 16'hDEAD, 1, 16'hA010,
        "R3 cpu priority read");
    rd_start(10'h010, 1, 16'hA010, "R3 no write happened");

    // R10: deselect, step ignored, other select polarities.
    cyc(1, 0, 0, 0, 0, 1, 1, 1, 2'b11, 10'h013, 16'h0, 0, 16'h0, "R10 deselect");
    step_rd(0, 0, 16'h0, "R10 step ignored");
    cyc(1, 0, 0, 1, 1, 1, 1, 1, 2'b11, 10'h013, 16'h0, 0, 16'h0, "R1 sel_c high");
    cyc(1, 0, 1, 1, 0, 1, 1, 1, 2'b11, 10'h013, 16'h0, 0, 16'h0, "R1 sel_a high");
    rd_start(10'h012, 0, 16'h0, "R9 first read masked");
    step_rd(0, 1, 16'hA013, "R9 next read driven");

    // R2: cpu strobe with sel_a high ignored, burst keeps stepping.
    cyc(0, 1, 1, 1, 0, 0, 1, 1, 2'b11, 10'h020, 16'h0, 1, 16'hA010,
        "R2 cpu strobe ignored");
    step_rd(0, 1, 16'hA0BB, "R2 burst continues");

    cyc(1, 1, 0, 1, 0, 1, 1, 1, 2'b11, 10'h0, 16'h0, 1, 16'hA0BB, "R5 hold end");
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule